// File: doc/BRIEF.md
# Power-Good Latch and Power-Down Sequencer

The block serves a single dual-purpose input pin. Before the pin is first seen high it acts as a power-good strobe. On that first high sample the block captures a 2-bit frequency/spread select code exactly once and decodes it into a frequency setting and a spread setting that stay fixed from then on. A third select input tells the block that the upper select line sits at a middle level. In that case the binary value of that line is ignored and one of two higher frequencies with no spread is chosen.

After the strobe, the same pin becomes an asynchronous active-low power-down request, brought into the clock domain by a synchronizer chain. The sequencer walks through a wait for power-good, a PLL lock wait timed by a cycle counter, and a run state. On a power-down request it first stops the output clocks, holds them stopped for a fixed number of output-clock edges, and only then drops the oscillator/VCO enable. Releasing power-down re-enables the oscillator and repeats the lock wait before the clocks run again.

Top module: `pwrgd_pd_seq`

## Requirements
- R1: During and after synchronous reset, with the pin low, the outputs are osc_en=1, lock_wait=0, clk_run=0, freq_code=0 (100 MHz) and spread_code=0 (off). They stay that way while the pin stays low.
- R2: The pin passes through SYNC_STAGES (default 2) synchronizer flops. A change of the pin made between edges shows up on the sequencer outputs after the third rising clock edge, and not after the second.
- R3: On the first synchronized high sample of the pin, the select code {sel1,sel0} is latched and decoded with freq_code=0 (100 MHz): 00 gives spread_code 0 (off), 01 gives 1 (-0.5 %), 10 gives 2 (+/-0.25 %) and 11 gives 3 (-0.75 %). The new codes appear at the same edge at which lock_wait rises.
- R4: When sel1_mid=1 at the latch, sel1 is ignored and spread_code=0. sel0=0 gives freq_code=1 (125 MHz) and sel0=1 gives freq_code=2 (200 MHz).
- R5: After the latch, changes on sel0, sel1 and sel1_mid, and later rising edges of the pin, leave freq_code and spread_code unchanged.
- R6: lock_wait stays high for exactly LOCK_CYCLES clock cycles. Then it falls, and clk_run rises at the same edge. lock_wait and clk_run are never high together.
- R7: A low synchronized pin in the run or lock-wait state drops clk_run and lock_wait at the third edge. osc_en stays high for STOP_EDGES (default 2) more edges and then falls.
- R8: When the pin returns high while the oscillator is off, osc_en and lock_wait rise at the third edge, and the lock wait of R6 is repeated before clk_run rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference / output clock |
| rst | input | 1 | Synchronous active-high reset |
| pgpd_pin | input | 1 | Dual-purpose pin: power-good strobe, then active-low power-down (asynchronous) |
| sel0 | input | 1 | Select line 0 (pulled low by default) |
| sel1 | input | 1 | Select line 1 (pulled low by default) |
| sel1_mid | input | 1 | High when select line 1 is at the middle level |
| freq_code | output | 2 | Decoded frequency: 0=100 MHz, 1=125 MHz, 2=200 MHz |
| spread_code | output | 2 | Decoded spread: 0 off, 1 -0.5 %, 2 +/-0.25 %, 3 -0.75 % |
| osc_en | output | 1 | Crystal oscillator and VCO enable |
| lock_wait | output | 1 | High while the PLL lock timer runs |
| clk_run | output | 1 | Enable for the glitch-free output clock gate |

## Verification
The assertions assume that reset is applied before the first use and that the pin reaches the sequencer only through its synchronizer. They also assume that the lock-wait state is the only path out of the power-good wait, so the first rise of lock_wait marks the latch. The stimulus holds every select input steady across the strobe and changes the pin half a cycle away from the clock edge. It leaves the pin in each state long enough for the lock or stop window to finish before it moves again, except in the one case that deliberately cuts a lock wait short with a power-down.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    FREQ_100 = 2'd0,
    FREQ_125 = 2'd1,
    FREQ_200 = 2'd2
  } freq_e;

  typedef enum logic [1:0] {
    SPR_OFF    = 2'd0,
    SPR_DN050  = 2'd1,
    SPR_CTR025 = 2'd2,
    SPR_DN075  = 2'd3
  } spread_e;

  typedef enum logic [2:0] {
    ST_WAIT_PG = 3'd0,
    ST_LOCK    = 3'd1,
    ST_RUN     = 3'd2,
    ST_STOP    = 3'd3,
    ST_OFF     = 3'd4
  } seq_e;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pgs_sel_latch.sv
module pgs_sel_latch
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic       sel0,
  input  logic       sel1,
  input  logic       sel1_mid,
  output logic [1:0] freq_code,
  output logic [1:0] spread_code
);
  freq_e   freq_d;
  spread_e spr_d;

  always_comb begin
    if (sel1_mid) begin
      freq_d = sel0 ? FREQ_200 : FREQ_125;
      spr_d  = SPR_OFF;
    end else begin
      freq_d = FREQ_100;
      case ({sel1, sel0})
        2'b01:   spr_d = SPR_DN050;
        2'b10:   spr_d = SPR_CTR025;
        2'b11:   spr_d = SPR_DN075;
        default: spr_d = SPR_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_code   <= FREQ_100;
      spread_code <= SPR_OFF;
    end else if (capture) begin
      freq_code   <= freq_d;
      spread_code <= spr_d;
    end
  end
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pgs_pkg::*;
#(
  parameter int LOCK_CYCLES = 180000,
  parameter int STOP_EDGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic capture,
  output logic osc_en,
  output logic lock_wait,
  output logic clk_run
);
  localparam int MAXC = (LOCK_CYCLES > STOP_EDGES) ? LOCK_CYCLES : STOP_EDGES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYCLES - 1);
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_EDGES - 1);

  seq_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    capture = 1'b0;
    case (st_q)
      ST_WAIT_PG: if (pin_s) begin
        st_d    = ST_LOCK;
        cnt_d   = '0;
        capture = 1'b1;
      end
      ST_LOCK: begin
        if (!pin_s) begin
          st_d  = ST_STOP;
          cnt_d = '0;
        end else if (cnt_q == LOCK_LAST) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: if (!pin_s) begin
        st_d  = ST_STOP;
        cnt_d = '0;
      end
      ST_STOP: begin
        if (cnt_q == STOP_LAST) begin
          st_d  = ST_OFF;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OFF: if (pin_s) begin
        st_d  = ST_LOCK;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_WAIT_PG;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_WAIT_PG;
      cnt_q     <= '0;
      osc_en    <= 1'b1;
      lock_wait <= 1'b0;
      clk_run   <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      osc_en    <= (st_d != ST_OFF);
      lock_wait <= (st_d == ST_LOCK);
      clk_run   <= (st_d == ST_RUN);
    end
  end
endmodule

// File: rtl/pwrgd_pd_seq.sv
module pwrgd_pd_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 180000,
  parameter int STOP_EDGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pgpd_pin,
  input  logic       sel0,
  input  logic       sel1,
  input  logic       sel1_mid,
  output logic [1:0] freq_code,
  output logic [1:0] spread_code,
  output logic       osc_en,
  output logic       lock_wait,
  output logic       clk_run
);
  logic pin_s;
  logic capture;

  pgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pgpd_pin), .dout(pin_s)
  );

  pgs_fsm #(.LOCK_CYCLES(LOCK_CYCLES), .STOP_EDGES(STOP_EDGES)) u_fsm (
    .clk(clk), .rst(rst), .pin_s(pin_s), .capture(capture),
    .osc_en(osc_en), .lock_wait(lock_wait), .clk_run(clk_run)
  );

  pgs_sel_latch u_sel (
    .clk(clk), .rst(rst), .capture(capture),
    .sel0(sel0), .sel1(sel1), .sel1_mid(sel1_mid),
    .freq_code(freq_code), .spread_code(spread_code)
  );
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk #(
  parameter int LOCK_CYCLES = 180000,
  parameter int STOP_EDGES  = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] freq_code,
  input logic [1:0] spread_code,
  input logic       osc_en,
  input logic       lock_wait,
  input logic       clk_run
);
  logic        seen_pg;
  logic [31:0] lw_cnt;
  logic [31:0] st_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_pg <= 1'b0;
      lw_cnt  <= '0;
      st_cnt  <= '0;
    end else begin
      seen_pg <= seen_pg | lock_wait;
      lw_cnt  <= lock_wait ? lw_cnt + 1 : 32'd0;
      st_cnt  <= (seen_pg && osc_en && !lock_wait && !clk_run) ? st_cnt + 1 : 32'd0;
    end
  end

  AST_RUN_LOCK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clk_run, lock_wait})); // R6
  AST_LOCK_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_run) |-> (lw_cnt == LOCK_CYCLES)); // R6
  AST_RUN_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    clk_run |-> osc_en); // R7
  AST_STOP_BEFORE_OFF: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> (!$past(clk_run) && st_cnt == STOP_EDGES)); // R7
  AST_SETTING_FROZEN: assert property (@(posedge clk) disable iff (rst)
    seen_pg |-> ($stable(freq_code) && $stable(spread_code))); // R5
  AST_NO_SPREAD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (freq_code != 2'd0) |-> (spread_code == 2'd0)); // R4
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !seen_pg && !lock_wait |-> (osc_en && !clk_run)); // R1
endmodule

bind pwrgd_pd_seq pgs_chk #(.LOCK_CYCLES(LOCK_CYCLES), .STOP_EDGES(STOP_EDGES)) u_chk (
  .clk(clk), .rst(rst), .freq_code(freq_code), .spread_code(spread_code),
  .osc_en(osc_en), .lock_wait(lock_wait), .clk_run(clk_run)
);

// File: tb/sim_pwrgd_pd_seq.sv
`timescale 1ns/1ps
module sim_pwrgd_pd_seq;
  localparam int L = 20;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic s0 = 1'b0, s1 = 1'b0, smid = 1'b0;
  logic [1:0] freq_code, spread_code;
  logic osc_en, lock_wait, clk_run;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrgd_pd_seq #(.SYNC_STAGES(2), .LOCK_CYCLES(L), .STOP_EDGES(S)) u0 (
    .clk(clk), .rst(rst), .pgpd_pin(pin), .sel0(s0), .sel1(s1), .sel1_mid(smid),
    .freq_code(freq_code), .spread_code(spread_code),
    .osc_en(osc_en), .lock_wait(lock_wait), .clk_run(clk_run)
  );

  // {mid, sel1, sel0, freq[1:0], spread[1:0]}
  localparam logic [6:0] VEC [7] = '{
    7'b000_00_00, 7'b001_00_01, 7'b010_00_10, 7'b011_00_11,
    7'b100_01_00, 7'b111_10_00, 7'b110_01_00
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; pin = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "lock_wait", lock_wait, 0);
    chk("R1", "clk_run", clk_run, 0);
    chk("R1", "freq", freq_code, 0);
    chk("R1", "spread", spread_code, 0);
    step(30);
    chk("R1", "lock_wait idle", lock_wait, 0);
    chk("R1", "clk_run idle", clk_run, 0);

    // R3 / R4 decode table
    for (int i = 0; i < 7; i++) begin
      do_reset();
      {smid, s1, s0} = VEC[i][6:4];
      step(2);
      pin = 1'b1;
      step(2);
      chk("R2", "lock_wait after 2 edges", lock_wait, 0);
      step(1);
      chk("R2", "lock_wait after 3 edges", lock_wait, 1);
      chk(VEC[i][6] ? "R4" : "R3", "freq", freq_code, int'(VEC[i][3:2]));
      chk(VEC[i][6] ? "R4" : "R3", "spread", spread_code, int'(VEC[i][1:0]));
      step(L - 1);
      chk("R6", "clk_run before lock end", clk_run, 0);
      chk("R6", "lock_wait before lock end", lock_wait, 1);
      step(1);
      chk("R6", "clk_run at lock end", clk_run, 1);
      chk("R6", "lock_wait at lock end", lock_wait, 0);
      {smid, s1, s0} = ~VEC[i][6:4];
      step(5);
      chk("R5", "freq after sel change", freq_code, int'(VEC[i][3:2]));
      chk("R5", "spread after sel change", spread_code, int'(VEC[i][1:0]));
    end

    // Last vector is 125 MHz / off, now in RUN. R7 power-down from run.
    pin = 1'b0;
    step(2);
    chk("R7", "clk_run still on", clk_run, 1);
    step(1);
    chk("R7", "clk_run stopped", clk_run, 0);
    chk("R7", "osc_en during stop", osc_en, 1);
    step(S - 1);
    chk("R7", "osc_en last stop edge", osc_en, 1);
    step(1);
    chk("R7", "osc_en off", osc_en, 0);

    // R8 release, with new select values and a second strobe (R5)
    {smid, s1, s0} = 3'b011;
    step(4);
    pin = 1'b1;
    step(2);
    chk("R8", "osc_en still off", osc_en, 0);
    step(1);
    chk("R8", "osc_en on", osc_en, 1);
    chk("R8", "lock_wait on", lock_wait, 1);
    chk("R5", "freq after restrobe", freq_code, 1);
    chk("R5", "spread after restrobe", spread_code, 0);
    step(L - 1);
    chk("R8", "clk_run before relock", clk_run, 0);
    step(1);
    chk("R8", "clk_run after relock", clk_run, 1);

    // R7 power-down during lock wait
    pin = 1'b0;
    step(3 + S + 2);
    chk("R7", "osc_en off again", osc_en, 0);
    pin = 1'b1;
    step(3 + 5);
    chk("R8", "lock_wait mid lock", lock_wait, 1);
    pin = 1'b0;
    step(3);
    chk("R7", "lock_wait dropped", lock_wait, 0);
    chk("R7", "clk_run stays off", clk_run, 0);
    chk("R7", "osc_en during stop from lock", osc_en, 1);
    step(S);
    chk("R7", "osc_en off from lock", osc_en, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule